// File: doc/BRIEF.md
# Machine-Mode Interrupt Trap Unit

This block sits beside a simple in-order CPU pipeline and owns the machine-level trap state: the global interrupt enable and its saved copy, the per-source enable mask, the trap vector base and mode, the saved return address, the trap cause and a read-only view of the pending lines. It watches three level-sensitive interrupt lines (software, timer, external). When the pipeline marks an instruction boundary and an enabled source is pending while interrupts are globally enabled, it takes a trap. It does so by driving a redirect request whose target depends on the vector mode, and it updates the trap state on the following clock edge. A return-from-trap strobe redirects back to the saved address and restores the enable.

The pipeline reaches the CSRs through a single port that can write, set or clear bits. The read data on that port always shows the value the register held before the operation. Redirects are combinational in the cycle of the boundary or return strobe, so the pipeline can steer its fetch in that same cycle.

Top module: `irq_trap_unit`

## Requirements
- R1: After reset the status (0x300), enable (0x304), vector (0x305), return address (0x341) and cause (0x342) CSRs all read 0. No redirect is raised while reset is held, even with every line high and the boundary strobe high.
- R2: A trap is taken only in a cycle where `instr_boundary` is 1, status bit 3 (global enable) is 1, and an interrupt line is high with its enable bit set. The enable bits are bit 3 for software, bit 7 for timer and bit 11 for external. In every other cycle without `mret`, `redirect_valid` is 0.
- R3: When several enabled sources are pending, external (code 11) wins over software (code 3), which wins over timer (code 7).
- R4: On a taken trap, on the next edge: the return address becomes `pc_now` with bits [1:0] cleared; the cause becomes bit 31 set plus the code in the low bits; status bit 7 takes the old bit 3; status bit 3 becomes 0.
- R5: Vector CSR bit 0 selects the mode and bit 1 always reads 0. In mode 0 the trap target is the vector value with bits [1:0] cleared. In mode 1 the target is that base plus 4 times the cause code. Every redirect target has bits [1:0] equal to 0.
- R6: While `mret` is 1, `redirect_valid` is 1 and `redirect_pc` equals the return address CSR. On the next edge status bit 3 takes status bit 7, and status bit 7 becomes 1. A trap condition in the same cycle as `mret` is not taken.
- R7: Interrupts are level-sensitive. A source still high after a return is trapped again at the next qualifying boundary.
- R8: CSR port operations are `csr_op` 1 = write, 2 = set bits, 3 = clear bits and 0 = none. `csr_rdata` shows the addressed CSR before the update. Only status bits 3 and 7 and enable bits 3, 7 and 11 are stored.
- R9: The cause CSR and the pending CSR (0x344) ignore writes. The pending CSR shows the software, timer and external lines at bits 3, 7 and 11.
- R10: Writes to the return address CSR clear its bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 2 | 0 none, 1 write, 2 set bits, 3 clear bits |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Operand for the CSR operation |
| csr_rdata | output | XLEN | Addressed CSR value before the update |
| irq_soft | input | 1 | Software interrupt level |
| irq_timer | input | 1 | Timer interrupt level |
| irq_ext | input | 1 | External interrupt level |
| pc_now | input | XLEN | PC of the instruction at the boundary |
| instr_boundary | input | 1 | Pipeline may accept a trap this cycle |
| mret | input | 1 | Return-from-trap strobe |
| redirect_valid | output | 1 | Redirect fetch this cycle |
| redirect_pc | output | XLEN | Redirect target |

## Verification
A wrong enable or priority decision shows at `redirect_valid` and `redirect_pc` in the same cycle as the boundary strobe. A corrupted vector base or mode shows there as a misplaced target. Faults in the saved return address, the cause or the enable hand-off become visible one edge later: the next CSR read exposes them, and so does the redirect target of the next `mret`. A level source that fails to re-trap shows at the first qualifying boundary after the return.

// File: rtl/irq_trap_unit.sv
module irq_trap_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      csr_op,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            irq_soft,
  input  logic            irq_timer,
  input  logic            irq_ext,
  input  logic [XLEN-1:0] pc_now,
  input  logic            instr_boundary,
  input  logic            mret,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_IE     = 12'h304;
  localparam logic [11:0] A_TVEC   = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_PEND   = 12'h344;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] C_SOFT  = 4'd3;
  localparam logic [CODE_W-1:0] C_TIMER = 4'd7;
  localparam logic [CODE_W-1:0] C_EXT   = 4'd11;
  localparam logic [1:0] OP_WR = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;

  logic              gie, pie;
  logic              ie_soft, ie_timer, ie_ext;
  logic [XLEN-1:2]   tvec_base;
  logic              tvec_vec;
  logic [XLEN-1:2]   epc;
  logic              cause_intr;
  logic [CODE_W-1:0] cause_code;

  logic [XLEN-1:0] status_v, ie_v, pend_v, tvec_v, epc_v, cause_v, next_v;

  always_comb begin
    status_v = '0; status_v[3] = gie; status_v[7] = pie;
    ie_v = '0; ie_v[3] = ie_soft; ie_v[7] = ie_timer; ie_v[11] = ie_ext;
    pend_v = '0; pend_v[3] = irq_soft; pend_v[7] = irq_timer; pend_v[11] = irq_ext;
    cause_v = '0; cause_v[XLEN-1] = cause_intr; cause_v[CODE_W-1:0] = cause_code;
  end
  assign tvec_v = {tvec_base, 1'b0, tvec_vec};
  assign epc_v  = {epc, 2'b00};

  always_comb begin
    case (csr_addr)
      A_STATUS: csr_rdata = status_v;
      A_IE:     csr_rdata = ie_v;
      A_TVEC:   csr_rdata = tvec_v;
      A_EPC:    csr_rdata = epc_v;
      A_CAUSE:  csr_rdata = cause_v;
      A_PEND:   csr_rdata = pend_v;
      default:  csr_rdata = '0;
    endcase
    case (csr_op)
      OP_WR:   next_v = csr_wdata;
      OP_SET:  next_v = csr_rdata | csr_wdata;
      OP_CLR:  next_v = csr_rdata & ~csr_wdata;
      default: next_v = csr_rdata;
    endcase
  end

  logic hit_soft, hit_timer, hit_ext, take_trap;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   trap_pc;

  assign hit_soft  = irq_soft  & ie_soft;
  assign hit_timer = irq_timer & ie_timer;
  assign hit_ext   = irq_ext   & ie_ext;
  assign take_trap = instr_boundary & gie & ~mret & (hit_soft | hit_timer | hit_ext);
  assign trap_code = hit_ext ? C_EXT : (hit_soft ? C_SOFT : C_TIMER);
  assign trap_pc   = tvec_vec ? ({tvec_base, 2'b00} + (XLEN'(trap_code) << 2))
                              : {tvec_base, 2'b00};

  assign redirect_valid = mret | take_trap;
  assign redirect_pc    = mret ? epc_v : trap_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie <= 1'b0; pie <= 1'b0;
      ie_soft <= 1'b0; ie_timer <= 1'b0; ie_ext <= 1'b0;
      tvec_base <= '0; tvec_vec <= 1'b0;
      epc <= '0;
      cause_intr <= 1'b0; cause_code <= '0;
    end else begin
      if (csr_op != 2'd0) begin
        case (csr_addr)
          A_STATUS: begin gie <= next_v[3]; pie <= next_v[7]; end
          A_IE: begin
            ie_soft <= next_v[3]; ie_timer <= next_v[7]; ie_ext <= next_v[11];
          end
          A_TVEC: begin tvec_base <= next_v[XLEN-1:2]; tvec_vec <= next_v[0]; end
          A_EPC:  epc <= next_v[XLEN-1:2];
          default: ;
        endcase
      end
      if (take_trap) begin
        epc        <= pc_now[XLEN-1:2];
        cause_intr <= 1'b1;
        cause_code <= trap_code;
        pie        <= gie;
        gie        <= 1'b0;
      end else if (mret) begin
        gie <= pie;
        pie <= 1'b1;
      end
    end
  end

  AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> epc_v == {$past(pc_now[XLEN-1:2]), 2'b00}); // R4
  AST_TRAP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (!gie && pie)); // R4
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> cause_v[XLEN-1]); // R4
  AST_MRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && csr_op == 2'd0) |=> (gie == $past(pie) && pie)); // R6
  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc[1:0] == 2'b00); // R5
  AST_CAUSE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_trap |=> $stable(cause_v)); // R9
  AST_NO_REDIRECT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mret && !status_v[3]) |-> !redirect_valid); // R2

endmodule

// File: tb/irq_trap_unit_bench.sv
module irq_trap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = 12'h0;
  logic [31:0] csr_wdata = 32'h0;
  logic [31:0] csr_rdata;
  logic        irq_soft = 1'b0, irq_timer = 1'b0, irq_ext = 1'b0;
  logic [31:0] pc_now = 32'h0;
  logic        instr_boundary = 1'b0, mret_i = 1'b0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_trap_unit #(.XLEN(32)) u_irq_trap_unit (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_soft(irq_soft),
    .irq_timer(irq_timer), .irq_ext(irq_ext), .pc_now(pc_now),
    .instr_boundary(instr_boundary), .mret(mret_i),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

  localparam logic [11:0] ST = 12'h300, IE = 12'h304, TV = 12'h305,
                          EP = 12'h341, CA = 12'h342, PE = 12'h344;

  localparam int NV = 12;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, TV, 32'h1000_0103, 32'h1000_0101},
    {2'd2, TV, 32'h0000_0010, 32'h1000_0111},
    {2'd3, TV, 32'h1000_0000, 32'h0000_0111},
    {2'd1, IE, 32'hFFFF_FFFF, 32'h0000_0888},
    {2'd3, IE, 32'h0000_0080, 32'h0000_0808},
    {2'd2, IE, 32'h0000_0080, 32'h0000_0888},
    {2'd1, EP, 32'h1234_5677, 32'h1234_5674},
    {2'd1, CA, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd1, ST, 32'hFFFF_FFFF, 32'h0000_0088},
    {2'd3, ST, 32'h0000_0008, 32'h0000_0080},
    {2'd1, PE, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd1, TV, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] pre);
    @(negedge clk);
    csr_op = op; csr_addr = a; csr_wdata = d;
    #1 pre = csr_rdata;
    @(posedge clk); #1;
    csr_op = 2'd0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    csr(2'd0, a, 32'h0, v);
  endtask

  task automatic step(input logic b, input logic m, input logic [31:0] pc,
                      output logic rv, output logic [31:0] rp);
    @(negedge clk);
    instr_boundary = b; mret_i = m; pc_now = pc;
    #1 rv = redirect_valid; rp = redirect_pc;
    @(posedge clk); #1;
    instr_boundary = 1'b0; mret_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, rp;
    logic rv;
    // R1: reset with everything asserted
    irq_soft = 1; irq_timer = 1; irq_ext = 1; instr_boundary = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 redirect in reset", 32'(redirect_valid), 32'h0);
    instr_boundary = 0; irq_soft = 0; irq_timer = 0; irq_ext = 0;
    rst_n = 1;
    rd(ST, v); chk("R1 status", v, 0);
    rd(IE, v); chk("R1 enable", v, 0);
    rd(TV, v); chk("R1 vector", v, 0);
    rd(EP, v); chk("R1 epc", v, 0);
    rd(CA, v); chk("R1 cause", v, 0);

    // R8 R9 R10 R5: CSR vector table
    for (int i = 0; i < NV; i++) begin
      csr(VEC[i][77:76], VEC[i][75:64], VEC[i][63:32], v);
      rd(VEC[i][75:64], v);
      chk($sformatf("R8 vec %0d", i), v, VEC[i][31:0]);
    end

    // R2: timer pending, enabled, but global enable off
    csr(2'd1, IE, 32'h80, v);
    irq_timer = 1;
    step(1, 0, 32'h100, rv, rp); chk("R2 global off", 32'(rv), 0);
    csr(2'd1, TV, 32'h2000_0000, v);
    csr(2'd1, ST, 32'h8, v);
    step(0, 0, 32'h100, rv, rp); chk("R2 no boundary", 32'(rv), 0);
    step(1, 0, 32'h106, rv, rp);
    chk("R2 trap taken", 32'(rv), 1);
    chk("R5 direct target", rp, 32'h2000_0000);
    rd(EP, v); chk("R4 epc", v, 32'h104);
    rd(CA, v); chk("R4 cause", v, 32'h8000_0007);
    rd(ST, v); chk("R4 status", v, 32'h80);
    step(1, 0, 32'h108, rv, rp); chk("R4 masked after trap", 32'(rv), 0);
    rd(PE, v); chk("R9 pending view", v, 32'h80);

    // R6 R7: return and level re-trap
    step(0, 1, 32'h0, rv, rp);
    chk("R6 mret valid", 32'(rv), 1);
    chk("R6 mret target", rp, 32'h104);
    rd(ST, v); chk("R6 status restore", v, 32'h88);
    step(1, 0, 32'h200, rv, rp);
    chk("R7 retrap", 32'(rv), 1);
    chk("R7 retrap target", rp, 32'h2000_0000);

    // R3 R5: priority with vectored mode
    csr(2'd1, TV, 32'h2000_0001, v);
    csr(2'd1, IE, 32'h888, v);
    irq_soft = 1; irq_ext = 1;
    step(0, 1, 32'h0, rv, rp); chk("R6 mret to 0x200", rp, 32'h200);
    step(1, 0, 32'h300, rv, rp); chk("R3 ext first", rp, 32'h2000_002C);
    rd(CA, v); chk("R3 cause ext", v, 32'h8000_000B);
    irq_ext = 0;
    step(0, 1, 32'h0, rv, rp);
    step(1, 0, 32'h400, rv, rp); chk("R3 soft second", rp, 32'h2000_000C);
    rd(CA, v); chk("R3 cause soft", v, 32'h8000_0003);
    irq_soft = 0;
    step(0, 1, 32'h0, rv, rp);
    step(1, 0, 32'h500, rv, rp); chk("R3 timer last", rp, 32'h2000_001C);

    // R6: mret wins over a boundary in the same cycle
    step(1, 1, 32'h600, rv, rp);
    chk("R6 precedence target", rp, 32'h500);
    rd(EP, v); chk("R6 no trap epc", v, 32'h500);
    rd(CA, v); chk("R6 no trap cause", v, 32'h8000_0007);

    // R8: read data shows the old value
    csr(2'd1, EP, 32'h0000_0ABC, v); chk("R8 pre value", v, 32'h500);
    rd(EP, v); chk("R10 epc aligned", v, 32'h0000_0ABC & ~32'h3);

    // R2: enable bit cleared blocks the trap
    csr(2'd3, IE, 32'h80, v);
    step(1, 0, 32'h700, rv, rp); chk("R2 source masked", 32'(rv), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule